// File: doc/BRIEF.md
# Masked Packed Quadword Subtract Unit

This block is an execution-lane unit for a vector datapath. It splits two 512-bit source vectors into 64-bit elements and subtracts each element of the second vector from the matching element of the first. The result is written into a 512-bit destination built from the old destination value. How each lane is written depends on the active vector length, a per-lane write mask, a merge or zero policy for masked-off lanes, and an optional broadcast of the lowest element of the second source.

Two encoding styles are supported. In the older style there is no masking and no broadcast, and destination bits above the active length keep their previous contents. In the newer style masking and broadcast apply, and every destination bit at or above the active length is cleared. The result is registered. It appears one clock after an input strobe, together with an output valid.

Top module: `qsub_lane_unit`

## Requirements
- R1: Each computed 64-bit lane equals the first-source element minus the second-source element, modulo 2^64. The borrow is dropped, the same result serves signed and unsigned data, and no status flag exists.
- R2: `vlen_sel` sets the number of active lanes: 2'b00 gives 2 lanes (128 bits), 2'b01 gives 4 lanes (256 bits), 2'b10 and 2'b11 give 8 lanes (512 bits). Lane j occupies `[64j+63:64j]`.
- R3: In new mode (`enc_new`=1) with `mask_en`=1, an active lane j is computed when `mask[j]`=1.
- R4: In new mode with `mask_en`=1 and `zero_mode`=0, an active lane whose mask bit is 0 keeps its `dest_old` value.
- R5: In new mode with `mask_en`=1 and `zero_mode`=1, an active lane whose mask bit is 0 becomes zero.
- R6: When `mask_en`=0, every active lane is computed regardless of `mask` and `zero_mode`.
- R7: In new mode with `bcast`=1, every computed lane subtracts bits [63:0] of `src_b` in place of its own element.
- R8: In new mode, every lane at or above the active lane count is zero. Mask bits of such lanes have no effect.
- R9: In legacy mode (`enc_new`=0), lanes above the active count keep `dest_old`. `mask_en`, `mask`, `zero_mode` and `bcast` have no effect, and every active lane is computed from its own elements.
- R10: `dest_new` and `out_valid` update one clock after a cycle with `in_valid`=1, with `out_valid`=1. After a cycle with `in_valid`=0, `out_valid` is 0 and `dest_new` holds its value.
- R11: Reset (`rst_n`=0) clears `dest_new` to zero and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | Minuend vector |
| src_b | input | 512 | Subtrahend vector |
| vlen_sel | input | 2 | Active length code |
| enc_new | input | 1 | 1 selects the new encoding style, 0 the legacy style |
| mask_en | input | 1 | Enables the per-lane write mask |
| mask | input | 8 | Per-lane write mask, bit j for lane j |
| zero_mode | input | 1 | 1 zeroes masked-off lanes, 0 merges them |
| bcast | input | 1 | Replicates the low element of `src_b` |
| dest_old | input | 512 | Previous destination value |
| out_valid | output | 1 | Result strobe |
| dest_new | output | 512 | Registered new destination |

## Verification
The assertions assume that every control and data input is at a known level whenever `in_valid` is high, and that `in_valid` stays low while reset is applied. Properties that look at a previous cycle's sources rely on those inputs having been sampled in the same cycle as the strobe. The bench changes inputs only on falling edges and holds `in_valid` low through reset. Its sweep covers all four length codes, including the spare code 2'b11, together with every mask value.

// File: rtl/qsub_pkg.sv
package qsub_pkg;
    parameter int unsigned QS_ELEM_W    = 64;
    parameter int unsigned QS_MAX_LANES = 8;
    parameter int unsigned QS_MIN_LANES = 2;
    parameter int unsigned QS_VSEL_W    = 2;
endpackage

// File: rtl/qsub_lane_ctrl.sv
module qsub_lane_ctrl #(
    parameter int unsigned MAX_LANES = qsub_pkg::QS_MAX_LANES,
    parameter int unsigned MIN_LANES = qsub_pkg::QS_MIN_LANES,
    parameter int unsigned VSEL_W    = qsub_pkg::QS_VSEL_W
) (
    input  logic [VSEL_W-1:0]    vlen_sel,
    input  logic                 enc_new,
    input  logic                 mask_en,
    input  logic [MAX_LANES-1:0] mask,
    output logic [MAX_LANES-1:0] lane_active,
    output logic [MAX_LANES-1:0] lane_wr
);
    logic [31:0] lane_cnt;

    always_comb begin
        lane_cnt = 32'(MIN_LANES) << vlen_sel;
        if (lane_cnt > 32'(MAX_LANES)) begin
            lane_cnt = 32'(MAX_LANES);
        end
        for (int unsigned j = 0; j < MAX_LANES; j++) begin
            lane_active[j] = (j < lane_cnt);
            // legacy style has no mask: always write
            lane_wr[j]     = !enc_new || !mask_en || mask[j];
        end
    end
endmodule

// File: rtl/qsub_bcast_sel.sv
module qsub_bcast_sel #(
    parameter int unsigned ELEM_W    = qsub_pkg::QS_ELEM_W,
    parameter int unsigned MAX_LANES = qsub_pkg::QS_MAX_LANES,
    localparam int unsigned VEC_W    = ELEM_W * MAX_LANES
) (
    input  logic [VEC_W-1:0] src_b,
    input  logic             use_bcast,
    output logic [VEC_W-1:0] b_eff
);
    for (genvar j = 0; j < MAX_LANES; j++) begin : g_sel
        assign b_eff[j*ELEM_W +: ELEM_W] = use_bcast ? src_b[ELEM_W-1:0]
                                                     : src_b[j*ELEM_W +: ELEM_W];
    end
endmodule

// File: rtl/qsub_lane.sv
module qsub_lane #(
    parameter int unsigned ELEM_W = qsub_pkg::QS_ELEM_W
) (
    input  logic [ELEM_W-1:0] a_elem,
    input  logic [ELEM_W-1:0] b_elem,
    input  logic [ELEM_W-1:0] old_elem,
    input  logic              active,
    input  logic              wr_en,
    input  logic              zero_mode,
    input  logic              enc_new,
    output logic [ELEM_W-1:0] res
);
    logic [ELEM_W-1:0] diff;

    // wraps modulo 2^ELEM_W, borrow discarded
    assign diff = a_elem - b_elem;

    always_comb begin
        if (!active) begin
            res = enc_new ? '0 : old_elem;
        end else if (wr_en) begin
            res = diff;
        end else if (zero_mode) begin
            res = '0;
        end else begin
            res = old_elem;
        end
    end
endmodule

// File: rtl/qsub_lane_unit.sv
module qsub_lane_unit #(
    parameter int unsigned ELEM_W    = qsub_pkg::QS_ELEM_W,
    parameter int unsigned MAX_LANES = qsub_pkg::QS_MAX_LANES,
    parameter int unsigned VSEL_W    = qsub_pkg::QS_VSEL_W,
    localparam int unsigned VEC_W    = ELEM_W * MAX_LANES,
    localparam int unsigned LOW_W    = ELEM_W * qsub_pkg::QS_MIN_LANES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [VEC_W-1:0]     src_a,
    input  logic [VEC_W-1:0]     src_b,
    input  logic [VSEL_W-1:0]    vlen_sel,
    input  logic                 enc_new,
    input  logic                 mask_en,
    input  logic [MAX_LANES-1:0] mask,
    input  logic                 zero_mode,
    input  logic                 bcast,
    input  logic [VEC_W-1:0]     dest_old,
    output logic                 out_valid,
    output logic [VEC_W-1:0]     dest_new
);
    typedef struct packed {
        logic             valid;
        logic [VEC_W-1:0] dest;
    } state_t;

    state_t state_d, state_q;

    logic [MAX_LANES-1:0] lane_active;
    logic [MAX_LANES-1:0] lane_wr;
    logic [VEC_W-1:0]     b_eff;
    logic [VEC_W-1:0]     lane_res;
    logic                 use_bcast;

    assign use_bcast = enc_new && bcast;

    qsub_lane_ctrl #(
        .MAX_LANES (MAX_LANES),
        .MIN_LANES (qsub_pkg::QS_MIN_LANES),
        .VSEL_W    (VSEL_W)
    ) u_ctrl (
        .vlen_sel    (vlen_sel),
        .enc_new     (enc_new),
        .mask_en     (mask_en),
        .mask        (mask),
        .lane_active (lane_active),
        .lane_wr     (lane_wr)
    );

    qsub_bcast_sel #(
        .ELEM_W    (ELEM_W),
        .MAX_LANES (MAX_LANES)
    ) u_bsel (
        .src_b     (src_b),
        .use_bcast (use_bcast),
        .b_eff     (b_eff)
    );

    for (genvar j = 0; j < MAX_LANES; j++) begin : g_lane
        qsub_lane #(
            .ELEM_W (ELEM_W)
        ) u_lane (
            .a_elem    (src_a[j*ELEM_W +: ELEM_W]),
            .b_elem    (b_eff[j*ELEM_W +: ELEM_W]),
            .old_elem  (dest_old[j*ELEM_W +: ELEM_W]),
            .active    (lane_active[j]),
            .wr_en     (lane_wr[j]),
            .zero_mode (zero_mode),
            .enc_new   (enc_new),
            .res       (lane_res[j*ELEM_W +: ELEM_W])
        );
    end

    always_comb begin
        state_d       = state_q;
        state_d.valid = in_valid;
        if (in_valid) begin
            state_d.dest = lane_res;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.valid;
    assign dest_new  = state_q.dest;

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(dest_new))); // R10
    AST_LANE0_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (!enc_new || !bcast) && (!enc_new || !mask_en || mask[0]))
        |=> dest_new[ELEM_W-1:0] == ($past(src_a[ELEM_W-1:0]) - $past(src_b[ELEM_W-1:0]))); // R1
    AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_new && vlen_sel == '0)
        |=> dest_new[VEC_W-1:LOW_W] == '0); // R8
    AST_UPPER_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !enc_new && vlen_sel == '0)
        |=> dest_new[VEC_W-1:LOW_W] == $past(dest_old[VEC_W-1:LOW_W])); // R9
    AST_ZERO_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && enc_new && mask_en && zero_mode && mask == '0)
        |=> dest_new == '0); // R5
endmodule

// File: tb/test_qsub_lane_unit.sv
module test_qsub_lane_unit;
    localparam int EW = 64;
    localparam int NL = 8;
    localparam int VW = EW * NL;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] src_a = '0;
    logic [VW-1:0] src_b = '0;
    logic [1:0]    vlen_sel = 2'b00;
    logic          enc_new = 1'b0;
    logic          mask_en = 1'b0;
    logic [NL-1:0] mask = '0;
    logic          zero_mode = 1'b0;
    logic          bcast = 1'b0;
    logic [VW-1:0] dest_old = '0;
    logic          out_valid;
    logic [VW-1:0] dest_new;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    qsub_lane_unit i_qsub_lane_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .src_a     (src_a),
        .src_b     (src_b),
        .vlen_sel  (vlen_sel),
        .enc_new   (enc_new),
        .mask_en   (mask_en),
        .mask      (mask),
        .zero_mode (zero_mode),
        .bcast     (bcast),
        .dest_old  (dest_old),
        .out_valid (out_valid),
        .dest_new  (dest_new)
    );

    function automatic logic [63:0] mix(input int unsigned s);
        logic [63:0] x;
        x = {32'h0, s} * 64'h9E37_79B9_7F4A_7C15;
        x = x ^ (x >> 31);
        x = x * 64'hBF58_476D_1CE4_E5B9;
        x = x ^ (x >> 27);
        return x;
    endfunction

    task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected result from the requirement text
    task automatic check_result();
        int n;
        logic [63:0] bj, ej;
        string tag;
        n = (vlen_sel == 2'b00) ? 2 : (vlen_sel == 2'b01) ? 4 : 8; // R2
        check("R10 out_valid", {511'b0, out_valid}, {511'b0, 1'b1});
        for (int j = 0; j < NL; j++) begin
            if (j >= n) begin
                ej  = enc_new ? 64'h0 : dest_old[j*EW +: EW];
                tag = enc_new ? "R8 inactive lane" : "R9 inactive lane";
            end else if (!enc_new || !mask_en || mask[j]) begin
                bj  = (enc_new && bcast) ? src_b[63:0] : src_b[j*EW +: EW];
                ej  = src_a[j*EW +: EW] - bj;
                tag = !enc_new ? "R9 legacy lane" : bcast ? "R7 broadcast lane" :
                      mask_en ? "R3 masked-on lane" : "R6 unmasked lane";
            end else begin
                ej  = zero_mode ? 64'h0 : dest_old[j*EW +: EW];
                tag = zero_mode ? "R5 zeroed lane" : "R4 merged lane";
            end
            check($sformatf("%s %0d", tag, j), {448'b0, dest_new[j*EW +: EW]}, {448'b0, ej});
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        int unsigned seed;
        logic [VW-1:0] held;
        seed = 1;
        repeat (3) @(negedge clk);
        check("R11 reset out_valid", {511'b0, out_valid}, '0);
        check("R11 reset dest_new", dest_new, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 wraparound corners, 512-bit length, new style, no mask
        vlen_sel = 2'b10; enc_new = 1'b1; mask_en = 1'b0; bcast = 1'b0;
        src_a = {64'h1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000,
                 64'h0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 64'h0};
        src_b = {64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1,
                 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 64'h1};
        in_valid = 1'b1;
        @(negedge clk);
        check("R1 wrap corners", dest_new,
              {64'h8000_0000_0000_0001, 64'h1, 64'h0, 64'h7FFF_FFFF_FFFF_FFFF,
               64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
               64'hFFFF_FFFF_FFFF_FFFF});

        // R10 idle hold
        held = dest_new;
        in_valid = 1'b0;
        src_a = ~src_a;
        @(negedge clk);
        check("R10 idle out_valid", {511'b0, out_valid}, '0);
        check("R10 idle hold", dest_new, held);

        // sweep every mode and mask value
        for (int v = 0; v < 4; v++) begin
            for (int m = 0; m < 16; m++) begin
                for (int k = 0; k < 256; k++) begin
                    vlen_sel  = v[1:0];
                    enc_new   = m[0];
                    mask_en   = m[1];
                    zero_mode = m[2];
                    bcast     = m[3];
                    mask      = k[7:0];
                    for (int j = 0; j < NL; j++) begin
                        src_a[j*EW +: EW]    = mix(seed * 32 + j);
                        src_b[j*EW +: EW]    = mix(seed * 32 + 8 + j);
                        dest_old[j*EW +: EW] = mix(seed * 32 + 16 + j);
                    end
                    seed++;
                    in_valid = 1'b1;
                    @(negedge clk);
                    check_result();
                end
            end
        end

        // R11 reset after activity
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 mid-run reset dest_new", dest_new, '0);
        check("R11 mid-run reset out_valid", {511'b0, out_valid}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule